// File: doc/BRIEF.md
# Round-Robin Burst Arbiter for a Shared SDRAM Port

This block lets several application modules share one external SDRAM command port. Each module raises a request line and waits until its grant is high. While it holds the grant it issues a single burst command, made up of a read/write flag, an address and a length code. Bursts are 1 to 8 words on a 64-bit data path. The arbiter then keeps that grant until every word of the burst has moved between the module and the memory side.

While the burst runs, the arbiter steers traffic to and from the owner. Write words come from the owner's data bus, and the memory's per-word take strobe is passed back to it. Read words go out on a shared bus, but the read-valid strobe reaches the owner only. The memory side is treated as a plain burst port. It raises one strobe per word after a fixed latency; with five wait cycles, an 8-word burst completes 14 cycles after its command. Grants rotate, so the module served most recently has the lowest priority the next time.

Top module: `sdarb_top`

## Requirements
- R1: While `rst_n` is low, `gnt_o` and `mem_cmd_valid_o` stay 0 whatever the request and command inputs do.
- R2: At most one bit of `gnt_o` is set, and a grant bit only rises for a module whose request was high in the cycle before.
- R3: Pending requests are served in rotating order starting after the last module granted. After reset, module 0 has the highest priority, so four simultaneous requests are granted in the order 0, 1, 2, 3.
- R4: A command pulse `cmd_go_i[k]` reaches the memory port only if module k holds the grant. A pulse from any other module produces no `mem_cmd_valid_o` and no grant.
- R5: Once a command is accepted, the grant stays on the same module until the last word of the burst has been transferred.
- R6: After the last word, `gnt_o` is 0 for at least one cycle before any module is granted again.
- R7: A request dropped before it is granted gives no grant and no memory command. If a granted module drops its request without issuing a command, the grant is released and no memory command is made.
- R8: `rvalid_o[k]` is set only for the granted module during one of its read bursts, once for each memory read strobe. `rdata_o` carries the memory read word.
- R9: During a write burst, `mem_wdata_o` carries the owner's `wdata_i` slice, and `wtake_o` is raised only for the owner.
- R10: A length code L (3 bits, 0 to 7) means a burst of L+1 words. The grant drops after exactly L+1 word strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NREQ | Request line per module |
| gnt_o | output | NREQ | Grant per module, at most one set |
| cmd_go_i | input | NREQ | One-cycle command pulse per module |
| cmd_we_i | input | NREQ | Command direction per module, 1 = write |
| cmd_addr_i | input | NREQ*AW | Burst start address per module, module k at bits k*AW upward |
| cmd_len_i | input | NREQ*LW | Length code per module (words minus one) |
| wdata_i | input | NREQ*DW | Write word per module |
| wtake_o | output | NREQ | Write word consumed this cycle, owner only |
| rdata_o | output | DW | Read word from memory |
| rvalid_o | output | NREQ | Read word valid, owner only |
| mem_cmd_valid_o | output | 1 | Burst command to memory |
| mem_cmd_we_o | output | 1 | Burst direction to memory |
| mem_cmd_addr_o | output | AW | Burst address to memory |
| mem_cmd_len_o | output | LW | Burst length code to memory |
| mem_wdata_o | output | DW | Write word to memory |
| mem_wr_take_i | input | 1 | Memory takes one write word this cycle |
| mem_rdata_i | input | DW | Read word from memory |
| mem_rvalid_i | input | 1 | Memory read word valid |

## Verification
The checks assume a well-behaved environment on both sides. Each granted module issues at most one command per grant and keeps its request high until it is granted or chooses to withdraw. The memory side raises exactly L+1 strobes per burst, all of the kind commanded, and none outside a burst. The bench's memory model starts its strobes only after it has seen a command, waits a fixed latency, then emits exactly length-code-plus-one strobes of the commanded kind. The bench's requester tasks drop their request in the same cycle as their single command pulse, so every stimulus stays within those assumptions.

// File: rtl/sdarb_pkg.sv
package sdarb_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_GRANT = 2'd1,
        ARB_BURST = 2'd2
    } arb_state_e;

    function automatic int unsigned idx_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sdarb_rr_pick.sv
module sdarb_rr_pick #(
    parameter int unsigned NREQ = 4,
    parameter int unsigned IW   = sdarb_pkg::idx_w(NREQ)
) (
    input  logic [NREQ-1:0] req_i,
    input  logic [IW-1:0]   last_i,
    output logic            win_valid_o,
    output logic [IW-1:0]   win_idx_o
);

    int cand;

    // Walk offsets from farthest to nearest so the nearest pending one wins.
    always_comb begin
        win_valid_o = 1'b0;
        win_idx_o   = '0;
        cand        = 0;
        for (int off = int'(NREQ); off >= 1; off--) begin
            cand = (int'(last_i) + off) % int'(NREQ);
            if (req_i[IW'(cand)]) begin
                win_valid_o = 1'b1;
                win_idx_o   = IW'(cand);
            end
        end
    end

endmodule

// File: rtl/sdarb_xfer_cnt.sv
module sdarb_xfer_cnt #(
    parameter int unsigned LW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [LW-1:0] len_i,
    input  logic          word_i,
    output logic          done_o,
    output logic          busy_o
);

    typedef struct packed {
        logic          busy;
        logic [LW-1:0] cnt;
        logic [LW-1:0] len;
    } cnt_s;

    cnt_s cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d.busy = 1'b1;
            cnt_d.cnt  = '0;
            cnt_d.len  = len_i;
        end else if (cnt_q.busy && word_i) begin
            if (cnt_q.cnt == cnt_q.len) begin
                cnt_d.busy = 1'b0;
            end else begin
                cnt_d.cnt = cnt_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = cnt_q.busy && word_i && (cnt_q.cnt == cnt_q.len);
    assign busy_o = cnt_q.busy;

    AST_CNT_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q.busy |-> (cnt_q.cnt <= cnt_q.len)); // R10
    AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !cnt_q.busy); // R5

endmodule

// File: rtl/sdarb_route.sv
module sdarb_route #(
    parameter int unsigned NREQ = 4,
    parameter int unsigned IW   = sdarb_pkg::idx_w(NREQ),
    parameter int unsigned DW   = 64
) (
    input  logic [IW-1:0]      owner_i,
    input  logic               in_burst_i,
    input  logic               sel_we_i,
    input  logic               mem_rvalid_i,
    input  logic               mem_wr_take_i,
    input  logic [NREQ*DW-1:0] wdata_i,
    output logic [DW-1:0]      mem_wdata_o,
    output logic [NREQ-1:0]    rvalid_o,
    output logic [NREQ-1:0]    wtake_o
);

    logic [DW-1:0] wd_arr [NREQ];

    for (genvar g = 0; g < NREQ; g++) begin : g_lane
        assign wd_arr[g]   = wdata_i[g*DW +: DW];
        assign rvalid_o[g] = in_burst_i && !sel_we_i && mem_rvalid_i
                             && (owner_i == IW'(g));
        assign wtake_o[g]  = in_burst_i && sel_we_i && mem_wr_take_i
                             && (owner_i == IW'(g));
    end

    assign mem_wdata_o = wd_arr[owner_i];

endmodule

// File: rtl/sdarb_top.sv
module sdarb_top #(
    parameter int unsigned NREQ = 4,
    parameter int unsigned AW   = 24,
    parameter int unsigned DW   = 64,
    parameter int unsigned MAXB = 8,
    parameter int unsigned LW   = $clog2(MAXB)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NREQ-1:0]      req_i,
    output logic [NREQ-1:0]      gnt_o,
    input  logic [NREQ-1:0]      cmd_go_i,
    input  logic [NREQ-1:0]      cmd_we_i,
    input  logic [NREQ*AW-1:0]   cmd_addr_i,
    input  logic [NREQ*LW-1:0]   cmd_len_i,
    input  logic [NREQ*DW-1:0]   wdata_i,
    output logic [NREQ-1:0]      wtake_o,
    output logic [DW-1:0]        rdata_o,
    output logic [NREQ-1:0]      rvalid_o,
    output logic                 mem_cmd_valid_o,
    output logic                 mem_cmd_we_o,
    output logic [AW-1:0]        mem_cmd_addr_o,
    output logic [LW-1:0]        mem_cmd_len_o,
    output logic [DW-1:0]        mem_wdata_o,
    input  logic                 mem_wr_take_i,
    input  logic [DW-1:0]        mem_rdata_i,
    input  logic                 mem_rvalid_i
);
    import sdarb_pkg::*;

    localparam int unsigned IW = idx_w(NREQ);

    typedef struct packed {
        arb_state_e    state;
        logic [IW-1:0] owner;
        logic [IW-1:0] last;
        logic          we;
    } arb_s;

    arb_s arb_d, arb_q;

    logic          win_valid;
    logic [IW-1:0] win_idx;
    logic          load;
    logic          word_evt;
    logic          burst_done;
    logic          cnt_busy;

    logic [AW-1:0] addr_arr [NREQ];
    logic [LW-1:0] len_arr  [NREQ];

    for (genvar g = 0; g < NREQ; g++) begin : g_cmd
        assign addr_arr[g] = cmd_addr_i[g*AW +: AW];
        assign len_arr[g]  = cmd_len_i[g*LW +: LW];
    end

    sdarb_rr_pick #(.NREQ(NREQ), .IW(IW)) u_pick (
        .req_i       (req_i),
        .last_i      (arb_q.last),
        .win_valid_o (win_valid),
        .win_idx_o   (win_idx)
    );

    always_comb begin
        arb_d = arb_q;
        load  = 1'b0;
        unique case (arb_q.state)
            ARB_IDLE: begin
                if (win_valid) begin
                    arb_d.state = ARB_GRANT;
                    arb_d.owner = win_idx;
                    arb_d.last  = win_idx;
                end
            end
            ARB_GRANT: begin
                if (cmd_go_i[arb_q.owner]) begin
                    arb_d.state = ARB_BURST;
                    arb_d.we    = cmd_we_i[arb_q.owner];
                    load        = 1'b1;
                end else if (!req_i[arb_q.owner]) begin
                    arb_d.state = ARB_IDLE;
                end
            end
            ARB_BURST: begin
                if (burst_done) begin
                    arb_d.state = ARB_IDLE;
                end
            end
            default: arb_d.state = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arb_q       <= '0;
            arb_q.state <= ARB_IDLE;
            arb_q.last  <= IW'(NREQ - 1);
        end else begin
            arb_q <= arb_d;
        end
    end

    always_comb begin
        gnt_o = '0;
        if (arb_q.state != ARB_IDLE) begin
            gnt_o[arb_q.owner] = 1'b1;
        end
    end

    assign word_evt = (arb_q.state == ARB_BURST)
                      && (arb_q.we ? mem_wr_take_i : mem_rvalid_i);

    sdarb_xfer_cnt #(.LW(LW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .len_i  (len_arr[arb_q.owner]),
        .word_i (word_evt),
        .done_o (burst_done),
        .busy_o (cnt_busy)
    );

    sdarb_route #(.NREQ(NREQ), .IW(IW), .DW(DW)) u_route (
        .owner_i       (arb_q.owner),
        .in_burst_i    (arb_q.state == ARB_BURST),
        .sel_we_i      (arb_q.we),
        .mem_rvalid_i  (mem_rvalid_i),
        .mem_wr_take_i (mem_wr_take_i),
        .wdata_i       (wdata_i),
        .mem_wdata_o   (mem_wdata_o),
        .rvalid_o      (rvalid_o),
        .wtake_o       (wtake_o)
    );

    assign mem_cmd_valid_o = (arb_q.state == ARB_GRANT) && cmd_go_i[arb_q.owner];
    assign mem_cmd_we_o    = cmd_we_i[arb_q.owner];
    assign mem_cmd_addr_o  = addr_arr[arb_q.owner];
    assign mem_cmd_len_o   = len_arr[arb_q.owner];
    assign rdata_o         = mem_rdata_i;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (gnt_o == '0) && !mem_cmd_valid_o); // R1
    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o)); // R2
    AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|gnt_o) |-> |($past(req_i) & gnt_o)); // R2
    AST_CMD_FROM_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid_o |-> |(cmd_go_i & gnt_o)); // R4
    AST_HOLD_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_q.state == ARB_BURST && !burst_done) |=> $stable(gnt_o) && (gnt_o != '0)); // R5
    AST_BURST_COUNTING: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_q.state == ARB_BURST) |-> cnt_busy); // R5
    AST_GAP_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> (gnt_o == '0)); // R6
    AST_RVALID_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid_o & ~gnt_o) == '0); // R8
    AST_WTAKE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (wtake_o & ~gnt_o) == '0); // R9

endmodule

// File: tb/tb_sdarb_top.sv
module tb_sdarb_top;

    localparam int N   = 4;
    localparam int AW  = 24;
    localparam int DW  = 64;
    localparam int LW  = 3;
    localparam int LAT = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [N-1:0]    req_v = '0, go_v = '0, we_v = '0;
    logic [AW-1:0]   addr_b [N];
    logic [LW-1:0]   len_b  [N];
    logic [DW-1:0]   wd_b   [N];
    logic [N*AW-1:0] cmd_addr;
    logic [N*LW-1:0] cmd_len;
    logic [N*DW-1:0] wdata;

    for (genvar g = 0; g < N; g++) begin : g_drv
        assign cmd_addr[g*AW +: AW] = addr_b[g];
        assign cmd_len[g*LW +: LW]  = len_b[g];
        assign wdata[g*DW +: DW]    = wd_b[g];
    end

    logic [N-1:0]  gnt_o, wtake_o, rvalid_o;
    logic [DW-1:0] rdata_o, mem_wdata_o;
    logic          mem_cmd_valid_o, mem_cmd_we_o;
    logic [AW-1:0] mem_cmd_addr_o;
    logic [LW-1:0] mem_cmd_len_o;
    logic          mem_wr_take_i = 1'b0, mem_rvalid_i = 1'b0;
    logic [DW-1:0] mem_rdata_i = '0;

    sdarb_top #(.NREQ(N), .AW(AW), .DW(DW), .MAXB(8)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_v), .gnt_o(gnt_o),
        .cmd_go_i(go_v), .cmd_we_i(we_v), .cmd_addr_i(cmd_addr), .cmd_len_i(cmd_len),
        .wdata_i(wdata), .wtake_o(wtake_o), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
        .mem_cmd_valid_o(mem_cmd_valid_o), .mem_cmd_we_o(mem_cmd_we_o),
        .mem_cmd_addr_o(mem_cmd_addr_o), .mem_cmd_len_o(mem_cmd_len_o),
        .mem_wdata_o(mem_wdata_o), .mem_wr_take_i(mem_wr_take_i),
        .mem_rdata_i(mem_rdata_i), .mem_rvalid_i(mem_rvalid_i)
    );

    int n_chk = 0, n_fail = 0;
    bit done_flag = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] wpat(input int id, input int k);
        return {16'(id), 16'hBEEF, 32'(k)};
    endfunction

    // Memory model: fixed latency, one strobe per word.
    int          mm_wait = 0, mm_left = 0, mm_k = 0;
    bit          mm_act = 0, mm_we = 0;
    logic [AW-1:0] mm_addr = '0;
    int          cmd_cnt = 0;
    logic [DW-1:0] wlog [64];
    int          wn = 0;

    initial begin
        forever begin
            @(posedge clk);
            if (mem_wr_take_i) begin
                wlog[wn % 64] = mem_wdata_o;
                wn++;
            end
            if (mem_cmd_valid_o) cmd_cnt++;
            mem_rvalid_i  <= 1'b0;
            mem_wr_take_i <= 1'b0;
            if (mem_cmd_valid_o) begin
                mm_act  <= 1'b1;
                mm_wait <= LAT;
                mm_left <= int'(mem_cmd_len_o) + 1;
                mm_we   <= mem_cmd_we_o;
                mm_addr <= mem_cmd_addr_o;
                mm_k    <= 0;
            end else if (mm_act) begin
                if (mm_wait > 0) begin
                    mm_wait <= mm_wait - 1;
                end else begin
                    mem_rvalid_i  <= !mm_we;
                    mem_wr_take_i <= mm_we;
                    mem_rdata_i   <= {8'hA5, mm_addr, 32'(mm_k)};
                    mm_k          <= mm_k + 1;
                    mm_left       <= mm_left - 1;
                    if (mm_left == 1) mm_act <= 1'b0;
                end
            end
        end
    end

    // Grant monitor: order log, per-module counts, handover and stray strobes.
    int glog [64];
    int gn = 0;
    int gcount [N];
    int handover_err = 0, stray_rv = 0;
    logic [N-1:0] prev_g = '0;

    initial begin
        for (int i = 0; i < N; i++) gcount[i] = 0;
        forever begin
            @(negedge clk);
            if (prev_g != '0 && gnt_o != '0 && gnt_o != prev_g) handover_err++;
            if (prev_g == '0 && gnt_o != '0) begin
                for (int i = 0; i < N; i++) if (gnt_o[i]) begin
                    glog[gn % 64] = i;
                    gn++;
                    gcount[i]++;
                end
            end
            if ((rvalid_o & ~gnt_o) != '0 || (wtake_o & ~gnt_o) != '0) stray_rv++;
            prev_g = gnt_o;
        end
    end

    task automatic run_burst(input int id, input bit we, input logic [AW-1:0] a,
                             input int lc, output int words, output int bad);
        int k;
        int r;
        k = 0; r = 0; bad = 0;
        wd_b[id] = wpat(id, 0);
        req_v[id] = 1'b1;
        @(negedge clk);
        while (!gnt_o[id]) @(negedge clk);
        go_v[id] = 1'b1; we_v[id] = we; addr_b[id] = a; len_b[id] = LW'(lc);
        req_v[id] = 1'b0;
        @(negedge clk);
        go_v[id] = 1'b0;
        while (gnt_o[id]) begin
            wd_b[id] = wpat(id, k);
            if (wtake_o[id]) k++;
            if (rvalid_o[id]) begin
                if (rdata_o != {8'hA5, a, 32'(r)}) bad++;
                r++;
            end
            @(negedge clk);
        end
        words = we ? k : r;
    endtask

    task automatic test_reset();
        req_v = '1; go_v[0] = 1'b1;
        repeat (3) @(negedge clk);
        chk(gnt_o == '0, "R1", "grant during reset", gnt_o, 0);
        chk(mem_cmd_valid_o == 1'b0, "R1", "command during reset", mem_cmd_valid_o, 0);
        req_v = '0; go_v = '0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(gnt_o == '0, "R1", "grant after release with no request", gnt_o, 0);
    endtask

    task automatic test_order();
        int w0, w1, w2, w3, b0, b1, b2, b3;
        int g0;
        g0 = gn;
        fork
            run_burst(0, 1'b0, 24'h000100, 1, w0, b0);
            run_burst(1, 1'b0, 24'h000200, 1, w1, b1);
            run_burst(2, 1'b0, 24'h000300, 1, w2, b2);
            run_burst(3, 1'b0, 24'h000400, 1, w3, b3);
        join
        for (int i = 0; i < N; i++)
            chk(glog[(g0 + i) % 64] == i, "R3", "rotation order after reset",
                glog[(g0 + i) % 64], i);
        chk(w0 + w1 + w2 + w3 == 8, "R10", "two words per code-1 burst", w0 + w1 + w2 + w3, 8);
        chk(b0 + b1 + b2 + b3 == 0, "R8", "read data in order burst", b0 + b1 + b2 + b3, 0);
    endtask

    task automatic test_write();
        int w, b, w0, bad;
        w0 = wn; bad = 0;
        run_burst(2, 1'b1, 24'h00ABC0, 7, w, b);
        chk(w == 8, "R10", "write takes seen by owner for code 7", w, 8);
        chk(wn - w0 == 8, "R5", "words written before grant dropped", wn - w0, 8);
        for (int k = 0; k < 8; k++) if (wlog[(w0 + k) % 64] != wpat(2, k)) bad++;
        chk(bad == 0, "R9", "write data from owner", bad, 0);
        chk(gnt_o == '0, "R6", "grant low after write burst", gnt_o, 0);
    endtask

    task automatic test_read();
        int w, b;
        run_burst(1, 1'b0, 24'h001230, 2, w, b);
        chk(w == 3, "R8", "read strobes to owner for code 2", w, 3);
        chk(b == 0, "R8", "read data matches memory", b, 0);
    endtask

    task automatic test_ignore_go();
        int c0, g3;
        c0 = cmd_cnt; g3 = gcount[3];
        go_v[3] = 1'b1; we_v[3] = 1'b1; addr_b[3] = 24'h0F0F00; len_b[3] = 3'd4;
        #1;
        chk(mem_cmd_valid_o == 1'b0, "R4", "command pulse without grant", mem_cmd_valid_o, 0);
        @(negedge clk);
        go_v[3] = 1'b0;
        repeat (3) @(negedge clk);
        chk(cmd_cnt == c0, "R4", "memory commands after stray pulse", cmd_cnt, c0);
        chk(gcount[3] == g3 && gnt_o == '0, "R4", "no grant from stray pulse", gcount[3], g3);
    endtask

    task automatic test_withdraw();
        int w, b, c0, g2;
        c0 = cmd_cnt; g2 = gcount[2];
        fork
            run_burst(1, 1'b0, 24'h002000, 7, w, b);
            begin
                repeat (3) @(negedge clk);
                req_v[2] = 1'b1;
                repeat (2) @(negedge clk);
                req_v[2] = 1'b0;
            end
        join
        repeat (3) @(negedge clk);
        chk(gcount[2] == g2, "R7", "withdrawn request granted", gcount[2], g2);
        chk(cmd_cnt == c0 + 1, "R7", "commands during withdraw test", cmd_cnt, c0 + 1);
        chk(w == 8 && b == 0, "R5", "long read completed intact", w, 8);
        c0 = cmd_cnt;
        req_v[3] = 1'b1;
        @(negedge clk);
        while (!gnt_o[3]) @(negedge clk);
        req_v[3] = 1'b0;
        repeat (2) @(negedge clk);
        chk(gnt_o == '0, "R7", "grant released by owner withdraw", gnt_o, 0);
        chk(cmd_cnt == c0, "R7", "no command on owner withdraw", cmd_cnt, c0);
    endtask

    task automatic test_resume();
        int w, b, w0, w2, w3, b0, b2, b3, g0;
        run_burst(1, 1'b0, 24'h003000, 0, w, b);
        chk(w == 1, "R10", "single word for code 0", w, 1);
        g0 = gn;
        fork
            run_burst(0, 1'b1, 24'h004000, 0, w0, b0);
            run_burst(2, 1'b1, 24'h005000, 0, w2, b2);
            run_burst(3, 1'b1, 24'h006000, 0, w3, b3);
        join
        chk(glog[g0 % 64] == 2, "R3", "first grant after module 1 served", glog[g0 % 64], 2);
        chk(glog[(g0 + 1) % 64] == 3, "R3", "second grant", glog[(g0 + 1) % 64], 3);
        chk(glog[(g0 + 2) % 64] == 0, "R3", "third grant wraps", glog[(g0 + 2) % 64], 0);
        chk(w0 + w2 + w3 == 3, "R10", "one take per code-0 write", w0 + w2 + w3, 3);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            addr_b[i] = '0; len_b[i] = '0; wd_b[i] = '0;
        end
        @(negedge clk);
        test_reset();
        test_order();
        test_write();
        test_read();
        test_ignore_go();
        test_withdraw();
        test_resume();
        chk(handover_err == 0, "R6", "direct grant handovers", handover_err, 0);
        chk(stray_rv == 0, "R8", "strobes to non-owner", stray_rv, 0);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule